// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbiter

This block is a synchronous memory with two fully independent ports, called left and right. Each port has its own enable, write select, output enable, address, write data and registered read data. Both ports can read or write any word in the same cycle as long as they point at different words.

When both ports are enabled on the same word, an arbiter grants that word to the port that was there first and raises a busy flag toward the other port. A write from the flagged port is dropped inside the block. Reads from the flagged port still complete.

A parameter sets the role of the instance. A master runs its own arbiter and drives the busy flags. A slave has no arbiter of its own: it takes the busy flags from a master on its busy inputs and uses them only to block writes. Several slaves can therefore sit beside one master to widen the data word, with a single arbitration decision for all of them.

Top module: `dual_port_arb_ram`

## Requirements
- R1: While reset is high and in the first cycle after it, both busy outputs are 0, both read-valid outputs are 0 and both read-data outputs are 0.
- R2: Accesses from the two ports to different addresses in the same cycle all complete. A write is `en=1, wr=1`, and the data can be read back on either port.
- R3: In master mode a busy output is 1 only when both enables are 1 and the two addresses are equal. When the two enabled ports point at different words, both flags are 0.
- R4: Arbitration depends only on enable and address. Two reads of the same word are arbitrated exactly like two writes.
- R5: A port whose enable and address were already held in the previous cycle wins against a port that arrives at that word now. The late port's busy flag rises in the same cycle its access begins.
- R6: The two busy outputs of a master are never 1 together. When both ports arrive at the same word in the same cycle, the left port wins and only `r_busy` is set.
- R7: A write presented while that port's busy is 1 leaves memory unchanged. A read presented while flagged still returns data.
- R8: The grant stays with the winner while both ports stay enabled on the same, unchanged address, even when the tie-break would now favour the other port. Both flags return to 0 in the cycle the addresses differ or an enable drops.
- R9: In slave mode (`IS_MASTER=0`) each busy output equals its busy input. A busy input of 1 blocks writes on that port only, and equal addresses alone raise no flag.
- R10: A port with `en=0` neither writes nor reads. When read-valid is 0, the read data is 0.
- R11: A read is `en=1, wr=0, oe=1`. Its data and `rvalid=1` appear on the clock edge that samples the request, and the data is the word as it was before any write in that same cycle. A read with `oe=0` gives `rvalid=0` and data 0.
- R12: In master mode the busy inputs have no effect on writes, reads or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write select (1 write, 0 read) |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_in | input | 1 | Left busy from a master (used in slave mode) |
| l_busy | output | 1 | Left busy flag |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write select (1 write, 0 read) |
| r_oe | input | 1 | Right output enable for reads |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_in | input | 1 | Right busy from a master (used in slave mode) |
| r_busy | output | 1 | Right busy flag |

## Verification
The properties check four things on every cycle of a master: the flags are mutually exclusive, a flag appears only on a real address match, every match flags exactly one side, and a held grant does not switch sides while neither port moves. On every cycle of either role they also check that read-valid only follows a read request and that idle read data is zero. Which port wins by arrival order, and the left-wins tie, depend on the history of the stimulus, so only the bench scenarios show them. The same holds for the dropping of a flagged write and for slave behaviour, which the bench shows by reading the memory back through the ports.

// File: rtl/dual_port_arb_ram_pkg.sv
package dual_port_arb_ram_pkg;

    // Which side currently holds a contended word
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Decoded per-port control
    typedef struct packed {
        logic en;
        logic wr;
        logic oe;
    } port_ctl_t;

    // Per-port actions after write blocking
    typedef struct packed {
        logic we;
        logic re;
    } port_act_t;

    localparam int NUM_PORTS = 2;

    function automatic port_act_t decode_port(input port_ctl_t c, input logic blocked);
        port_act_t a;
        a.we = c.en & c.wr & ~blocked;
        a.re = c.en & ~c.wr & c.oe;
        return a;
    endfunction

endpackage

// File: rtl/dual_port_arb_ram_arbiter.sv
module dual_port_arb_ram_arbiter
    import dual_port_arb_ram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    output logic          l_busy,
    output logic          r_busy
);

    logic          l_en_q, r_en_q;
    logic [AW-1:0] l_addr_q, r_addr_q, hold_addr_q;
    owner_e        owner_q, winner;
    logic          match, l_settled, r_settled;

    assign match     = l_en && r_en && (l_addr == r_addr);
    assign l_settled = l_en_q && (l_addr_q == l_addr);
    assign r_settled = r_en_q && (r_addr_q == r_addr);

    always_comb begin
        if (!match) begin
            winner = OWN_NONE;
        end else if (owner_q != OWN_NONE && hold_addr_q == l_addr) begin
            winner = owner_q;
        end else if (r_settled && !l_settled) begin
            winner = OWN_RIGHT;
        end else begin
            winner = OWN_LEFT;
        end
    end

    assign l_busy = (winner == OWN_RIGHT);
    assign r_busy = (winner == OWN_LEFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            l_en_q      <= 1'b0;
            r_en_q      <= 1'b0;
            l_addr_q    <= '0;
            r_addr_q    <= '0;
            hold_addr_q <= '0;
            owner_q     <= OWN_NONE;
        end else begin
            l_en_q      <= l_en;
            r_en_q      <= r_en;
            l_addr_q    <= l_addr;
            r_addr_q    <= r_addr;
            hold_addr_q <= l_addr;
            owner_q     <= winner;
        end
    end

endmodule

// File: rtl/dual_port_arb_ram_store.sv
module dual_port_arb_ram_store
    import dual_port_arb_ram_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  port_act_t [NUM_PORTS-1:0] act,
    input  logic [NUM_PORTS-1:0][AW-1:0] addr,
    input  logic [NUM_PORTS-1:0][DW-1:0] wdata,
    output logic [NUM_PORTS-1:0][DW-1:0] rdata,
    output logic [NUM_PORTS-1:0]         rvalid
);

    logic [DW-1:0] mem [DEPTH];

    // Writes: no reset on the array
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (act[p].we) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    // Registered reads, old data on same-cycle write
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                rvalid[p] <= act[p].re;
                rdata[p]  <= act[p].re ? mem[addr[p]] : '0;
            end
        end
    end

endmodule

// File: rtl/dual_port_arb_ram.sv
module dual_port_arb_ram
    import dual_port_arb_ram_pkg::*;
#(
    parameter int DEPTH     = 2048,
    parameter int DW        = 8,
    parameter bit IS_MASTER = 1'b1,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rvalid,
    input  logic          l_busy_in,
    output logic          l_busy,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rvalid,
    input  logic          r_busy_in,
    output logic          r_busy
);

    logic                          l_blk, r_blk;
    port_ctl_t [NUM_PORTS-1:0]     ctl;
    logic      [NUM_PORTS-1:0]     blk;
    port_act_t [NUM_PORTS-1:0]     act;
    logic [NUM_PORTS-1:0][AW-1:0]  addr;
    logic [NUM_PORTS-1:0][DW-1:0]  wdata, rdata;
    logic [NUM_PORTS-1:0]          rvalid;

    generate
        if (IS_MASTER) begin : g_master
            logic l_arb, r_arb;
            dual_port_arb_ram_arbiter #(.AW(AW)) u_arb (
                .clk    (clk),
                .rst    (rst),
                .l_en   (l_en),
                .l_addr (l_addr),
                .r_en   (r_en),
                .r_addr (r_addr),
                .l_busy (l_arb),
                .r_busy (r_arb)
            );
            // busy inputs are not consulted by a master
            assign l_blk = l_arb | (l_busy_in & 1'b0);
            assign r_blk = r_arb | (r_busy_in & 1'b0);
        end else begin : g_slave
            assign l_blk = l_busy_in;
            assign r_blk = r_busy_in;
        end
    endgenerate

    assign l_busy = l_blk;
    assign r_busy = r_blk;

    assign ctl[0]   = '{en: l_en, wr: l_wr, oe: l_oe};
    assign ctl[1]   = '{en: r_en, wr: r_wr, oe: r_oe};
    assign blk      = {r_blk, l_blk};
    assign addr     = {r_addr, l_addr};
    assign wdata    = {r_wdata, l_wdata};

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign act[p] = decode_port(ctl[p], blk[p]);
        end
    endgenerate

    dual_port_arb_ram_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    assign l_rdata  = rdata[0];
    assign r_rdata  = rdata[1];
    assign l_rvalid = rvalid[0];
    assign r_rvalid = rvalid[1];

endmodule

// File: rtl/dual_port_arb_ram_chk.sv
module dual_port_arb_ram_chk #(
    parameter int AW        = 11,
    parameter int DW        = 8,
    parameter bit IS_MASTER = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          l_en,
    input logic          l_wr,
    input logic          l_oe,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_rdata,
    input logic          l_rvalid,
    input logic          l_busy,
    input logic          r_en,
    input logic          r_wr,
    input logic          r_oe,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_rdata,
    input logic          r_rvalid,
    input logic          r_busy
);

    logic same_word;
    assign same_word = l_en && r_en && (l_addr == r_addr);

    generate
        if (IS_MASTER) begin : g_arb_props
            p_busy_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
                !(l_busy && r_busy));

            p_busy_needs_match_r3: assert property (@(posedge clk) disable iff (rst)
                (l_busy || r_busy) |-> same_word);

            p_match_flagged_r6: assert property (@(posedge clk) disable iff (rst)
                same_word |-> (l_busy || r_busy));

            p_right_grant_kept_r8: assert property (@(posedge clk) disable iff (rst)
                r_busy |=> ((l_en && r_en && $stable(l_addr) && $stable(r_addr)) -> r_busy));

            p_left_grant_kept_r8: assert property (@(posedge clk) disable iff (rst)
                l_busy |=> ((l_en && r_en && $stable(l_addr) && $stable(r_addr)) -> l_busy));
        end
    endgenerate

    p_l_valid_from_read_r11: assert property (@(posedge clk) disable iff (rst)
        l_rvalid |-> $past(l_en && !l_wr && l_oe));

    p_r_valid_from_read_r11: assert property (@(posedge clk) disable iff (rst)
        r_rvalid |-> $past(r_en && !r_wr && r_oe));

    p_l_idle_data_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !l_rvalid |-> (l_rdata == '0));

    p_r_idle_data_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !r_rvalid |-> (r_rdata == '0));

endmodule

bind dual_port_arb_ram dual_port_arb_ram_chk #(
    .AW(AW), .DW(DW), .IS_MASTER(IS_MASTER)
) u_chk (
    .clk(clk), .rst(rst),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy(r_busy)
);

// File: tb/test_dual_port_arb_ram.sv
module test_dual_port_arb_ram;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NROWS = 18;

    typedef struct packed {
        logic le, lw, lo; logic [10:0] la; logic [7:0] ld;
        logic re, rw, ro; logic [10:0] ra; logic [7:0] rd;
        logic xlb, xrb;
        logic xlv; logic [7:0] xld;
        logic xrv; logic [7:0] xrd;
    } vec_t;

    // Rows are applied in order; arrival history matters.
    localparam vec_t VEC [NROWS] = '{
        // 0 R2/R12: both write, different words
        '{1,1,0,11'h010,8'h11, 1,1,0,11'h020,8'h22, 0,0, 0,8'h00, 0,8'h00},
        // 1 R2/R3: cross reads, different words
        '{1,0,1,11'h020,8'h00, 1,0,1,11'h010,8'h00, 0,0, 1,8'h22, 1,8'h11},
        // 2 left settles on 0x010
        '{1,0,1,11'h010,8'h00, 0,0,0,11'h000,8'h00, 0,0, 1,8'h11, 0,8'h00},
        // 3 R4/R5: right read arrives late
        '{1,0,1,11'h010,8'h00, 1,0,1,11'h010,8'h00, 0,1, 1,8'h11, 1,8'h11},
        // 4 R7/R8: right write while flagged
        '{1,0,1,11'h010,8'h00, 1,1,0,11'h010,8'h99, 0,1, 1,8'h11, 0,8'h00},
        // 5 R7/R8: right leaves, word unchanged
        '{1,0,1,11'h010,8'h00, 0,0,0,11'h000,8'h00, 0,0, 1,8'h11, 0,8'h00},
        // 6 right writes 0x030
        '{0,0,0,11'h000,8'h00, 1,1,0,11'h030,8'h33, 0,0, 0,8'h00, 0,8'h00},
        // 7 R5: right settled, left write arrives
        '{1,1,0,11'h030,8'h44, 1,0,1,11'h030,8'h00, 1,0, 0,8'h00, 1,8'h33},
        // 8 R7: left write was dropped
        '{0,0,0,11'h000,8'h00, 1,0,1,11'h030,8'h00, 0,0, 0,8'h00, 1,8'h33},
        // 9 R6: same-cycle arrival, left wins
        '{1,1,0,11'h040,8'h55, 1,1,0,11'h040,8'h66, 0,1, 0,8'h00, 0,8'h00},
        // 10 R6/R7: left data kept
        '{1,0,1,11'h040,8'h00, 0,0,0,11'h000,8'h00, 0,0, 1,8'h55, 0,8'h00},
        // 11 R11: read with oe low
        '{0,0,0,11'h000,8'h00, 1,0,0,11'h040,8'h00, 0,0, 0,8'h00, 0,8'h00},
        // 12 R10: disabled write
        '{0,1,1,11'h040,8'hEE, 0,0,0,11'h000,8'h00, 0,0, 0,8'h00, 0,8'h00},
        // 13 R10: word untouched
        '{1,0,1,11'h040,8'h00, 0,0,0,11'h000,8'h00, 0,0, 1,8'h55, 0,8'h00},
        // 14 right settles on 0x040
        '{0,0,0,11'h000,8'h00, 1,0,1,11'h040,8'h00, 0,0, 0,8'h00, 1,8'h55},
        // 15 R5: left arrives late
        '{1,0,1,11'h040,8'h00, 1,0,1,11'h040,8'h00, 1,0, 1,8'h55, 1,8'h55},
        // 16 R8: grant held by right
        '{1,0,1,11'h040,8'h00, 1,0,1,11'h040,8'h00, 1,0, 1,8'h55, 1,8'h55},
        // 17 R3/R8: addresses split
        '{1,0,1,11'h040,8'h00, 1,0,1,11'h010,8'h00, 0,0, 1,8'h55, 1,8'h11}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // master
    logic l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
    logic l_rvalid, r_rvalid, l_busy, r_busy;
    logic m_busy_in = 1'b1;

    // slave
    logic s_l_en = 0, s_l_wr = 0, s_l_oe = 0, s_r_en = 0, s_r_wr = 0, s_r_oe = 0;
    logic [AW-1:0] s_l_addr = '0, s_r_addr = '0;
    logic [DW-1:0] s_l_wdata = '0, s_r_wdata = '0, s_l_rdata, s_r_rdata;
    logic s_l_rvalid, s_r_rvalid, s_l_busy, s_r_busy;
    logic s_l_busy_in = 0, s_r_busy_in = 0;

    dual_port_arb_ram #(.DEPTH(2048), .DW(DW), .IS_MASTER(1'b1)) i_dual_port_arb_ram (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_busy_in(m_busy_in), .l_busy(l_busy),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_busy_in(m_busy_in), .r_busy(r_busy)
    );

    dual_port_arb_ram #(.DEPTH(2048), .DW(DW), .IS_MASTER(1'b0)) i_dual_port_arb_ram_slave (
        .clk(clk), .rst(rst),
        .l_en(s_l_en), .l_wr(s_l_wr), .l_oe(s_l_oe), .l_addr(s_l_addr), .l_wdata(s_l_wdata),
        .l_rdata(s_l_rdata), .l_rvalid(s_l_rvalid), .l_busy_in(s_l_busy_in), .l_busy(s_l_busy),
        .r_en(s_r_en), .r_wr(s_r_wr), .r_oe(s_r_oe), .r_addr(s_r_addr), .r_wdata(s_r_wdata),
        .r_rdata(s_r_rdata), .r_rvalid(s_r_rvalid), .r_busy_in(s_r_busy_in), .r_busy(s_r_busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0: return "R2/R12";  1: return "R2/R3";   2: return "R11";
            3: return "R4/R5";   4: return "R7/R8";   5: return "R7/R8";
            6: return "R2";      7: return "R5";      8: return "R7";
            9: return "R6";      10: return "R6/R7";  11: return "R11";
            12: return "R10";    13: return "R10";    14: return "R11";
            15: return "R5";     16: return "R8";     default: return "R3/R8";
        endcase
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1 l_busy", {31'b0, l_busy}, 0);
        chk("R1 r_busy", {31'b0, r_busy}, 0);
        chk("R1 l_rvalid", {31'b0, l_rvalid}, 0);
        chk("R1 r_rdata", {24'b0, r_rdata}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 l_rdata after reset", {24'b0, l_rdata}, 0);
        chk("R1 r_rvalid after reset", {31'b0, r_rvalid}, 0);

        for (int i = 0; i < NROWS; i++) begin
            {l_en, l_wr, l_oe, l_addr, l_wdata} = {VEC[i].le, VEC[i].lw, VEC[i].lo, VEC[i].la, VEC[i].ld};
            {r_en, r_wr, r_oe, r_addr, r_wdata} = {VEC[i].re, VEC[i].rw, VEC[i].ro, VEC[i].ra, VEC[i].rd};
            #2;
            chk($sformatf("%s row %0d l_busy", row_tag(i), i), {31'b0, l_busy}, {31'b0, VEC[i].xlb});
            chk($sformatf("%s row %0d r_busy", row_tag(i), i), {31'b0, r_busy}, {31'b0, VEC[i].xrb});
            @(negedge clk);
            chk($sformatf("%s row %0d l_rvalid", row_tag(i), i), {31'b0, l_rvalid}, {31'b0, VEC[i].xlv});
            chk($sformatf("%s row %0d l_rdata", row_tag(i), i), {24'b0, l_rdata}, {24'b0, VEC[i].xld});
            chk($sformatf("%s row %0d r_rvalid", row_tag(i), i), {31'b0, r_rvalid}, {31'b0, VEC[i].xrv});
            chk($sformatf("%s row %0d r_rdata", row_tag(i), i), {24'b0, r_rdata}, {24'b0, VEC[i].xrd});
        end
        {l_en, r_en} = 2'b00;

        // R9: slave write with busy input low
        s_l_en = 1; s_l_wr = 1; s_l_addr = 11'h005; s_l_wdata = 8'h5A; s_l_busy_in = 0;
        #2;
        chk("R9 slave l_busy follows input 0", {31'b0, s_l_busy}, 0);
        @(negedge clk);
        // R9: busy input high blocks the write
        s_l_wdata = 8'hA5; s_l_busy_in = 1;
        #2;
        chk("R9 slave l_busy follows input 1", {31'b0, s_l_busy}, 1);
        @(negedge clk);
        // R9: read still allowed while busy input high
        s_l_wr = 0; s_l_oe = 1;
        @(negedge clk);
        chk("R9 slave blocked write, read valid", {31'b0, s_l_rvalid}, 1);
        chk("R9 slave blocked write, old data", {24'b0, s_l_rdata}, 8'h5A);
        // R9: same word on both ports raises no flag in a slave
        s_l_busy_in = 0; s_r_busy_in = 0;
        s_r_en = 1; s_r_wr = 0; s_r_oe = 1; s_r_addr = 11'h005;
        #2;
        chk("R9 slave no own arbitration l", {31'b0, s_l_busy}, 0);
        chk("R9 slave no own arbitration r", {31'b0, s_r_busy}, 0);
        @(negedge clk);
        chk("R9 slave right read data", {24'b0, s_r_rdata}, 8'h5A);
        s_l_en = 0; s_r_en = 0;
        @(negedge clk);

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule